// File: doc/BRIEF.md
# Platform Sleep State Sequencer

This block tracks the platform's global power state: working (S0), suspend-to-RAM (S3), suspend-to-disk (S4), soft off (S5) and mechanical off (G3). Each clock it decides the next state from a software sleep request with its target type, a set of maskable wake sources, a forced-off override, power-fail and power-return indications, an active-low battery-low signal and a retained after-power-loss policy bit. A retained flag records whether S4 was the state in force when power was lost, so that a later power return can resume suspend-to-disk.

From the state register the block drives four active-low plane controls: the S3, S4 and S5 rails and the suspend-well rail. Each is registered, so a plane control changes exactly one clock after the state changes and cannot glitch. The current state is also brought out as a 3-bit code. The core reset is asserted asynchronously and released through a two-flop synchronizer, and after reset the block sits in G3 until power returns.

Top module: `sleep_sequencer`

## Requirements
- R1: While reset is asserted and until the first transition after its release, the state output reads G3 (3'd7) and all four rail controls are driven low.
- R2: In S0, a sleep request whose type is 3'b101, 3'b110 or 3'b111 moves the state on the next clock to S3, S4 or S5 respectively.
- R3: In S0, a sleep request with any other type code has no effect, and the state stays S0.
- R4: The override moves S0, S3 or S4 to S5 on the next clock and takes priority over sleep requests and wake events. In S5 and G3 it has no effect.
- R5: A power-fail indication moves any state to G3 on the next clock and has priority over every other input.
- R6: In S3, S4 or S5, a wake event whose per-source enable bit is set moves the state to S0. Wake events whose enable bit is clear, and all wake events in S0 or G3, have no effect.
- R7: In G3 with power returned, a policy bit of 1 selects S0. A policy bit of 0 selects S4 if S4 was the state when G3 was entered, and S5 otherwise. Without power return, G3 is held.
- R8: While the battery-low input is low, no transition from S3, S4, S5 or G3 into S0 takes place, and the state stays where it is.
- R9: The rails follow the state. The S3 rail is low in S3, S4, S5 and G3. The S4 rail is low in S4, S5 and G3. The S5 rail is low in S5 and G3. The suspend-well rail is low only in G3.
- R10: The rail controls change exactly one clock after the state output changes, and in the clock where the state changes they still show the previous state.
- R11: The state output encodes S0 as 3'd0, S3 as 3'd3, S4 as 3'd4, S5 as 3'd5 and G3 as 3'd7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| slp_req_i | input | 1 | Sleep request, acted on in S0 |
| slp_type_i | input | 3 | Target sleep type: 101 = S3, 110 = S4, 111 = S5 |
| wake_i | input | N_WAKE | Wake event per source |
| wake_en_i | input | N_WAKE | Enable per wake source |
| force_off_i | input | 1 | Override that forces soft off |
| pwr_fail_i | input | 1 | Power failure or mechanical off |
| pwr_ret_i | input | 1 | Power has returned (acted on in G3) |
| batlow_n_i | input | 1 | Battery low, active low; holds back entry into S0 |
| resume_on_i | input | 1 | Retained policy: 1 = go to S0 on power return |
| state_o | output | 3 | Current state code |
| rail_s3_n_o | output | 1 | S3 plane control, active low |
| rail_s4_n_o | output | 1 | S4 plane control, active low |
| rail_s5_n_o | output | 1 | S5 plane control, active low |
| rail_sus_n_o | output | 1 | Suspend-well plane control, active low |

## Verification
The bench builds the block with N_WAKE = 3. With that width, a small fixed set of request/enable pairs covers sources that are enabled, sources that are masked and more than one enabled source at a time. For each of the six starting conditions (S0, S3, S4, S5, and G3 with the S4 flag clear or set), it applies every combination of power-fail, override, power-return, battery-low, policy bit, five sleep-request variants and those wake patterns. The expected next state and rail pattern are computed arithmetically in the bench. The rails are checked in the clock where the state moves and again one clock later, which exposes both a wrong rail value and a wrong delay.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5,
    PS_G3 = 3'd7
  } pstate_e;

  localparam logic [2:0] TYPE_S3 = 3'b101;
  localparam logic [2:0] TYPE_S4 = 3'b110;
  localparam logic [2:0] TYPE_S5 = 3'b111;

  typedef struct packed {
    logic s3_n;
    logic s4_n;
    logic s5_n;
    logic sus_n;
  } rails_t;

endpackage

// File: rtl/sleep_wake_gate.sv
module sleep_wake_gate #(
  parameter int N_WAKE = 4
) (
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  output logic              wake_any_o
);

  logic [N_WAKE-1:0] hit;
  logic [N_WAKE:0]   chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < N_WAKE; g++) begin : g_src
    assign hit[g]     = wake_i[g] & wake_en_i[g];
    assign chain[g+1] = chain[g] | hit[g];
  end

  assign wake_any_o = chain[N_WAKE];

endmodule

// File: rtl/sleep_next_state.sv
module sleep_next_state
  import sleep_seq_pkg::*;
(
  input  pstate_e    state_q,
  input  logic       s4_lost_q,
  input  logic       slp_req_i,
  input  logic [2:0] slp_type_i,
  input  logic       wake_any_i,
  input  logic       force_off_i,
  input  logic       pwr_fail_i,
  input  logic       pwr_ret_i,
  input  logic       batlow_n_i,
  input  logic       resume_on_i,
  output pstate_e    state_d
);

  logic    on_ok;
  pstate_e sleep_tgt;
  logic    sleep_valid;

  assign on_ok = batlow_n_i;

  always_comb begin
    sleep_valid = 1'b1;
    sleep_tgt   = PS_S0;
    unique case (slp_type_i)
      TYPE_S3: sleep_tgt = PS_S3;
      TYPE_S4: sleep_tgt = PS_S4;
      TYPE_S5: sleep_tgt = PS_S5;
      default: sleep_valid = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (pwr_fail_i) begin
      state_d = PS_G3;
    end else begin
      unique case (state_q)
        PS_S0: begin
          if (force_off_i)                     state_d = PS_S5;
          else if (slp_req_i && sleep_valid)   state_d = sleep_tgt;
        end
        PS_S3, PS_S4: begin
          if (force_off_i)                     state_d = PS_S5;
          else if (wake_any_i && on_ok)        state_d = PS_S0;
        end
        PS_S5: begin
          if (wake_any_i && on_ok)             state_d = PS_S0;
        end
        PS_G3: begin
          if (pwr_ret_i) begin
            if (resume_on_i) begin
              if (on_ok)                       state_d = PS_S0;
            end else if (s4_lost_q) begin
              state_d = PS_S4;
            end else begin
              state_d = PS_S5;
            end
          end
        end
        default: state_d = PS_G3;
      endcase
    end
  end

endmodule

// File: rtl/sleep_rail_reg.sv
module sleep_rail_reg
  import sleep_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_core_n,
  input  pstate_e state_q,
  output rails_t  rails_q
);

  rails_t rails_d;
  logic   rails_en;

  always_comb begin
    rails_d = '{s3_n: 1'b1, s4_n: 1'b1, s5_n: 1'b1, sus_n: 1'b1};
    unique case (state_q)
      PS_S0: ;
      PS_S3: rails_d.s3_n = 1'b0;
      PS_S4: begin
        rails_d.s3_n = 1'b0;
        rails_d.s4_n = 1'b0;
      end
      PS_S5: begin
        rails_d.s3_n = 1'b0;
        rails_d.s4_n = 1'b0;
        rails_d.s5_n = 1'b0;
      end
      default: rails_d = '0;
    endcase
  end

  assign rails_en = (rails_d != rails_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   rails_q <= '0;
    else if (rails_en) rails_q <= rails_d;
  end

  // R9
  rail_nesting_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!rails_q.sus_n |-> !rails_q.s5_n) and (!rails_q.s5_n |-> !rails_q.s4_n)
    and (!rails_q.s4_n |-> !rails_q.s3_n));

endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
  import sleep_seq_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slp_req_i,
  input  logic [2:0]        slp_type_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic              force_off_i,
  input  logic              pwr_fail_i,
  input  logic              pwr_ret_i,
  input  logic              batlow_n_i,
  input  logic              resume_on_i,
  output logic [2:0]        state_o,
  output logic              rail_s3_n_o,
  output logic              rail_s4_n_o,
  output logic              rail_s5_n_o,
  output logic              rail_sus_n_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  pstate_e                state_q;
  pstate_e                state_d;
  logic                   state_en;
  logic                   s4_lost_q;
  logic                   s4_lost_en;
  logic                   wake_any;
  rails_t                 rails_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  sleep_wake_gate #(.N_WAKE(N_WAKE)) u_wake (
    .wake_i     (wake_i),
    .wake_en_i  (wake_en_i),
    .wake_any_o (wake_any)
  );

  sleep_next_state u_next (
    .state_q     (state_q),
    .s4_lost_q   (s4_lost_q),
    .slp_req_i   (slp_req_i),
    .slp_type_i  (slp_type_i),
    .wake_any_i  (wake_any),
    .force_off_i (force_off_i),
    .pwr_fail_i  (pwr_fail_i),
    .pwr_ret_i   (pwr_ret_i),
    .batlow_n_i  (batlow_n_i),
    .resume_on_i (resume_on_i),
    .state_d     (state_d)
  );

  assign state_en   = (state_d != state_q);
  assign s4_lost_en = (state_d == PS_G3) && (state_q != PS_G3);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   state_q <= PS_G3;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)     s4_lost_q <= 1'b0;
    else if (s4_lost_en) s4_lost_q <= (state_q == PS_S4);
  end

  sleep_rail_reg u_rails (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .state_q    (state_q),
    .rails_q    (rails_q)
  );

  assign state_o      = state_q;
  assign rail_s3_n_o  = rails_q.s3_n;
  assign rail_s4_n_o  = rails_q.s4_n;
  assign rail_s5_n_o  = rails_q.s5_n;
  assign rail_sus_n_o = rails_q.sus_n;

  // R5
  fail_to_g3_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    pwr_fail_i |=> (state_o == 3'd7));

  // R4
  override_s5_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!pwr_fail_i && force_off_i &&
     (state_o == 3'd0 || state_o == 3'd3 || state_o == 3'd4)) |=> (state_o == 3'd5));

  // R8
  batlow_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o != 3'd0 && !batlow_n_i) |=> (state_o != 3'd0));

  // R3
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 3'd0 && !pwr_fail_i && !force_off_i && slp_req_i &&
     slp_type_i != 3'b101 && slp_type_i != 3'b110 && slp_type_i != 3'b111)
    |=> (state_o == 3'd0));

  // R7
  ret_off_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 3'd7 && !pwr_fail_i && pwr_ret_i && !resume_on_i)
    |=> (state_o == ($past(s4_lost_q) ? 3'd4 : 3'd5)));

  // R10
  rail_lag_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> (rail_s3_n_o == ($past(state_o) == 3'd0)) &&
             (rail_sus_n_o == ($past(state_o) != 3'd7)));

endmodule

// File: tb/sleep_sequencer_test.sv
module sleep_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slp_req, force_off, pwr_fail, pwr_ret, batlow_n, resume_on;
  logic [2:0]    slp_type;
  logic [NW-1:0] wake, wake_en;
  logic [2:0]    state;
  logic          r3, r4, r5, rsus;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_sequencer #(.N_WAKE(NW)) uut (
    .clk(clk), .rst_n(rst_n), .slp_req_i(slp_req), .slp_type_i(slp_type),
    .wake_i(wake), .wake_en_i(wake_en), .force_off_i(force_off),
    .pwr_fail_i(pwr_fail), .pwr_ret_i(pwr_ret), .batlow_n_i(batlow_n),
    .resume_on_i(resume_on), .state_o(state), .rail_s3_n_o(r3),
    .rail_s4_n_o(r4), .rail_s5_n_o(r5), .rail_sus_n_o(rsus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    slp_req = 0; slp_type = 0; wake = 0; wake_en = 0; force_off = 0;
    pwr_fail = 0; pwr_ret = 0; batlow_n = 1; resume_on = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] rails_of(input logic [2:0] s);
    // {s3_n, s4_n, s5_n, sus_n}
    return {s == 3'd0, s == 3'd0 || s == 3'd3, s != 3'd5 && s != 3'd7, s != 3'd7};
  endfunction

  function automatic logic [2:0] model(input logic [2:0] s, input bit flag, input bit fail,
                                       input bit ovr, input bit ret, input bit req,
                                       input logic [2:0] ty, input bit wk, input bit bat,
                                       input bit pol);
    logic [2:0] nx;
    nx = s;
    if (fail) nx = 3'd7;
    else if (s == 3'd0) begin
      if (ovr) nx = 3'd5;
      else if (req && ty >= 3'd5) nx = ty - 3'd2;
    end else if (s == 3'd3 || s == 3'd4) begin
      if (ovr) nx = 3'd5;
      else if (wk && bat) nx = 3'd0;
    end else if (s == 3'd5) begin
      if (wk && bat) nx = 3'd0;
    end else if (ret) begin
      if (pol) nx = bat ? 3'd0 : 3'd7;
      else nx = flag ? 3'd4 : 3'd5;
    end
    return nx;
  endfunction

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R1: reset state and rails
    check("R1 state in reset", 32'(state), 32'd7);
    check("R1 rails in reset", 32'({r3, r4, r5, rsus}), 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // 0:S0 1:S3 2:S4 3:S5 4:G3 flag clear 5:G3 flag set
  task automatic go_to(input int idx);
    do_reset();
    if (idx != 4) begin
      pwr_ret = 1; resume_on = 1; step(); quiet();
      if (idx == 1) begin slp_req = 1; slp_type = 3'b101; step(); quiet(); end
      if (idx == 2 || idx == 5) begin slp_req = 1; slp_type = 3'b110; step(); quiet(); end
      if (idx == 3) begin force_off = 1; step(); quiet(); end
      if (idx == 5) begin pwr_fail = 1; step(); quiet(); end
    end
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] start, exp, ty;
    logic [NW-1:0] w, e;
    bit flag, req, wk;
    string tag;
    rst_n = 0;
    quiet();
    do_reset();
    check("R11 G3 code after reset", 32'(state), 32'd7);
    for (int s = 0; s < 6; s++) begin
      start = (s == 0) ? 3'd0 : (s == 1) ? 3'd3 : (s == 2) ? 3'd4 : (s == 3) ? 3'd5 : 3'd7;
      flag  = (s == 5);
      for (int f = 0; f < 2; f++)
      for (int o = 0; o < 2; o++)
      for (int r = 0; r < 2; r++)
      for (int sl = 0; sl < 5; sl++)
      for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
      for (int wi = 0; wi < 6; wi++) begin
        go_to(s);
        check("R11 start state", 32'(state), 32'(start));
        req = (sl != 0);
        ty  = (sl == 1) ? 3'b101 : (sl == 2) ? 3'b110 : (sl == 3) ? 3'b111 : 3'b011;
        case (wi)
          0: begin w = 3'b000; e = 3'b111; end
          1: begin w = 3'b111; e = 3'b000; end
          2: begin w = 3'b001; e = 3'b001; end
          3: begin w = 3'b010; e = 3'b101; end
          4: begin w = 3'b100; e = 3'b100; end
          default: begin w = 3'b101; e = 3'b010; end
        endcase
        wk = |(w & e);
        pwr_fail = f[0]; force_off = o[0]; pwr_ret = r[0]; slp_req = req;
        slp_type = ty; batlow_n = b[0]; resume_on = p[0]; wake = w; wake_en = e;
        exp = model(start, flag, f[0], o[0], r[0], req, ty, wk, b[0], p[0]);
        if (f != 0) tag = "R5";
        else if (start == 3'd7) tag = "R7";
        else if (o != 0) tag = "R4";
        else if (start == 3'd0) tag = (sl == 4) ? "R3" : "R2";
        else if (b == 0) tag = "R8";
        else tag = "R6";
        step();
        check({tag, " next state"}, 32'(state), 32'(exp));
        // R10: rails still show the old state
        check("R10 rails one clock late", 32'({r3, r4, r5, rsus}), 32'(rails_of(start)));
        quiet();
        step();
        check("R9 rails match state", 32'({r3, r4, r5, rsus}), 32'(rails_of(exp)));
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule